// File: doc/BRIEF.md
# NAND Command Front End with Status Register

This block is the device-side command and address interpreter for a memory with a multiplexed 8-bit bus. A system clock samples the bus and the strobes. The write strobe and the read strobe pass through two-flop synchronizers, and the block acts on their edges. On a write-strobe rising edge with chip select low, the latch-select lines decide whether the byte is a command, an address byte or a data byte. Address bytes fill a column register and a row register. Data bytes leave the block as write strobes into an external page register, tagged with the current column.

Recognised command pairs start an array operation. The start is a one-cycle pulse with an operation code. The array reports back through a completion input and a fail flag. While an operation runs, a busy flag filters the commands. The status byte and a fixed five-byte identification sequence are read back with the read strobe. In page-data mode, the read strobe returns the external page byte at the current column and then advances the column.

Top module: `nand_cmd_front`

## Requirements
- R1: A byte is taken only on a write-strobe rising edge while chip select is low. Command latch high makes it a command, address latch high makes it an address byte, and both low make it a data byte. With chip select high, the edge is ignored.
- R2: Address bytes fill, in order: column bits 7:0, column bits 11:8 (taken from bus bits 3:0, upper bus nibble dropped), row bits 7:0, then row bits 15:8. Address bytes beyond the expected count are ignored.
- R3: Command 00h, four address bytes, then 30h pulses op_start with op_kind 0 and raises busy. 35h in place of 30h gives op_kind 1. After reset the block is already in read setup, so the 00h byte may be omitted.
- R4: 80h, four address bytes, at least one data byte, then 10h starts op_kind 2. Each data byte pulses wr_stb with wr_data and the column it lands on, and the next data byte goes to the column after it. A 10h with no data loaded starts nothing. 85h followed by two column bytes moves the data-input column.
- R5: 60h followed by two address bytes (row bits 7:0, then row bits 15:8), then D0h, starts op_kind 4.
- R6: While busy (busy_n low), every command other than 70h and FFh is dropped, and so are address and data bytes.
- R7: The status byte is {wp_n, not busy, array idle, 0, 0, 0, 0, fail}: bit 7 follows wp_n, bit 6 is 1 when ready, bit 5 is 1 when no array operation runs, bits 4 to 1 read 0, and bit 0 holds the op_fail value latched at op_done.
- R8: After 70h, every read-strobe cycle returns the status byte until another command arrives. 00h returns reads to page data.
- R9: FFh is accepted even while busy. It pulses op_abort, ends any array operation, clears the fail bit, and holds busy_n low for RST_BUSY_CYC+1 cycles.
- R10: 90h followed by address byte 00h makes successive read-strobe cycles return C8h, A1h, 80h, 15h, 40h, and 00h after that.
- R11: In page-data mode, each read-strobe falling edge returns the external byte at the current column and then advances the column by one. 05h, two column bytes, then E0h sets the column that the next read uses.
- R12: 80h, address, data, then 15h starts op_kind 3. busy_n returns high after CACHE_BUSY_CYC+1 cycles while status bit 5 stays 0. Status bit 5 rises at op_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe; rising edge takes a byte |
| re_n | input | 1 | Read strobe; falling edge loads bus_out |
| wp_n | input | 1 | Write-protect level, reported in status bit 7 |
| bus_in | input | 8 | Bus byte from the host |
| bus_out | output | 8 | Byte returned to the host |
| busy_n | output | 1 | Ready flag, 1 = ready |
| arr_rd_data | input | 8 | Page-register byte at col_addr |
| col_addr | output | COL_W | Current column |
| row_addr | output | ROW_W | Captured row |
| wr_stb | output | 1 | One-cycle data-write pulse |
| wr_data | output | 8 | Data byte for wr_stb |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 3 | Operation code: 0 read, 1 read-for-copy, 2 program, 3 cache program, 4 erase |
| op_abort | output | 1 | One-cycle abort pulse from FFh |
| op_done | input | 1 | Array operation finished |
| op_fail | input | 1 | Fail flag, valid with op_done |

## Verification
The checker assumes that op_done arrives only while an array operation is outstanding. The bench pulses op_done only after it has seen op_start. The properties also rely on each strobe edge lasting several clocks and on the bus and latch selects staying stable around it. The bench therefore holds every strobe level for four clocks and changes inputs only on falling clock edges. Expected bytes come from the stated encodings and from the bench's own page-data formula applied to the column it tracks.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
    typedef enum logic [1:0] {MD_ARRAY, MD_STATUS, MD_ID} rd_mode_e;
    typedef enum logic [2:0] {PD_NONE, PD_READ, PD_PROG, PD_ERASE, PD_RNDOUT, PD_ID} pend_e;

    localparam logic [2:0] OPK_READ  = 3'd0;
    localparam logic [2:0] OPK_RDCP  = 3'd1;
    localparam logic [2:0] OPK_PROG  = 3'd2;
    localparam logic [2:0] OPK_CACHE = 3'd3;
    localparam logic [2:0] OPK_ERASE = 3'd4;

    localparam logic [7:0] C_RD_SETUP  = 8'h00;
    localparam logic [7:0] C_RD_GO     = 8'h30;
    localparam logic [7:0] C_RDCP_GO   = 8'h35;
    localparam logic [7:0] C_PG_SETUP  = 8'h80;
    localparam logic [7:0] C_PG_COL    = 8'h85;
    localparam logic [7:0] C_PG_GO     = 8'h10;
    localparam logic [7:0] C_CACHE_GO  = 8'h15;
    localparam logic [7:0] C_ER_SETUP  = 8'h60;
    localparam logic [7:0] C_ER_GO     = 8'hD0;
    localparam logic [7:0] C_RO_SETUP  = 8'h05;
    localparam logic [7:0] C_RO_GO     = 8'hE0;
    localparam logic [7:0] C_STATUS    = 8'h70;
    localparam logic [7:0] C_IDENT     = 8'h90;
    localparam logic [7:0] C_RESET     = 8'hFF;
endpackage

// File: rtl/nand_edge_sync.sv
module nand_edge_sync #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= INIT;
            s2_q <= INIT;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign rise = s1_q & ~s2_q;
    assign fall = ~s1_q & s2_q;
endmodule

// File: rtl/nand_rsp_mux.sv
module nand_rsp_mux
    import nand_fe_pkg::*;
(
    input  rd_mode_e   mode,
    input  logic [7:0] status_b,
    input  logic [2:0] id_idx,
    input  logic [7:0] arr_byte,
    output logic [7:0] rsp
);
    logic [7:0] id_b;

    always_comb begin
        case (id_idx)
            3'd0:    id_b = 8'hC8;
            3'd1:    id_b = 8'hA1;
            3'd2:    id_b = 8'h80;
            3'd3:    id_b = 8'h15;
            3'd4:    id_b = 8'h40;
            default: id_b = 8'h00;
        endcase
        case (mode)
            MD_STATUS: rsp = status_b;
            MD_ID:     rsp = id_b;
            default:   rsp = arr_byte;
        endcase
    end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int COL_W          = 12,
    parameter int ROW_W          = 16,
    parameter int RST_BUSY_CYC   = 625,
    parameter int CACHE_BUSY_CYC = 375
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cle,
    input  logic             ale,
    input  logic             we_n,
    input  logic             re_n,
    input  logic             wp_n,
    input  logic [7:0]       bus_in,
    output logic [7:0]       bus_out,
    output logic             busy_n,
    input  logic [7:0]       arr_rd_data,
    output logic [COL_W-1:0] col_addr,
    output logic [ROW_W-1:0] row_addr,
    output logic             wr_stb,
    output logic [7:0]       wr_data,
    output logic             op_start,
    output logic [2:0]       op_kind,
    output logic             op_abort,
    input  logic             op_done,
    input  logic             op_fail
);
    localparam int TMR_MAX = (RST_BUSY_CYC > CACHE_BUSY_CYC) ? RST_BUSY_CYC : CACHE_BUSY_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int COL_HI  = COL_W - 8;

    typedef struct packed {
        rd_mode_e         mode;
        pend_e            pend;
        logic [2:0]       aidx;
        logic [2:0]       aend;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
        logic             rdy;
        logic             arr_busy;
        logic             fail;
        logic             tmr_run;
        logic [TMR_W-1:0] tmr;
        logic             loaded;
        logic [2:0]       id_idx;
        logic [7:0]       dout;
        logic             start;
        logic [2:0]       kind;
        logic             wr;
        logic [7:0]       wdat;
        logic             abort;
    } st_t;

    st_t st_d, st_q;

    logic we_rise, we_fall_unused, re_rise_unused, re_fall;
    logic [7:0] status_b, rsp_b;
    logic [15:0] col16, row16;

    nand_edge_sync #(.INIT(1'b1)) u_we_sync (
        .clk(clk), .rst_n(rst_n), .din(we_n), .rise(we_rise), .fall(we_fall_unused)
    );
    nand_edge_sync #(.INIT(1'b1)) u_re_sync (
        .clk(clk), .rst_n(rst_n), .din(re_n), .rise(re_rise_unused), .fall(re_fall)
    );

    assign status_b = {wp_n, st_q.rdy, ~st_q.arr_busy, 4'b0000, st_q.fail};

    nand_rsp_mux u_rsp (
        .mode(st_q.mode), .status_b(status_b), .id_idx(st_q.id_idx),
        .arr_byte(arr_rd_data), .rsp(rsp_b)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.wr    = 1'b0;
        st_d.abort = 1'b0;
        col16      = 16'(st_q.col);
        row16      = 16'(st_q.row);

        // column advance after a data write, once the strobe has been seen
        if (st_q.wr) begin
            st_d.col = st_q.col + 1'b1;
        end

        // busy timer (reset recovery or cache transfer)
        if (st_q.tmr_run) begin
            if (st_q.tmr == '0) begin
                st_d.tmr_run = 1'b0;
                st_d.rdy     = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr - 1'b1;
            end
        end

        // array completion
        if (op_done && st_q.arr_busy) begin
            st_d.arr_busy = 1'b0;
            st_d.fail     = op_fail;
            if (!st_q.tmr_run) begin
                st_d.rdy = 1'b1;
            end
        end

        if (we_rise && !ce_n) begin
            if (cle) begin
                if (bus_in == C_RESET) begin
                    st_d.abort    = 1'b1;
                    st_d.arr_busy = 1'b0;
                    st_d.fail     = 1'b0;
                    st_d.rdy      = 1'b0;
                    st_d.tmr_run  = 1'b1;
                    st_d.tmr      = TMR_W'(RST_BUSY_CYC);
                    st_d.pend     = PD_READ;
                    st_d.aidx     = 3'd0;
                    st_d.aend     = 3'd4;
                    st_d.mode     = MD_ARRAY;
                    st_d.loaded   = 1'b0;
                end else if (bus_in == C_STATUS) begin
                    st_d.mode = MD_STATUS;
                end else if (st_q.rdy) begin
                    case (bus_in)
                        C_RD_SETUP: begin
                            st_d.pend = PD_READ;
                            st_d.aidx = 3'd0;
                            st_d.aend = 3'd4;
                            st_d.mode = MD_ARRAY;
                        end
                        C_RD_GO, C_RDCP_GO: begin
                            if (st_q.pend == PD_READ && st_q.aidx == st_q.aend) begin
                                st_d.start    = 1'b1;
                                st_d.kind     = (bus_in == C_RD_GO) ? OPK_READ : OPK_RDCP;
                                st_d.rdy      = 1'b0;
                                st_d.arr_busy = 1'b1;
                                st_d.mode     = MD_ARRAY;
                            end
                            st_d.pend = PD_NONE;
                        end
                        C_PG_SETUP: begin
                            st_d.pend   = PD_PROG;
                            st_d.aidx   = 3'd0;
                            st_d.aend   = 3'd4;
                            st_d.loaded = 1'b0;
                        end
                        C_PG_COL: begin
                            if (st_q.pend == PD_PROG) begin
                                st_d.aidx = 3'd0;
                                st_d.aend = 3'd2;
                            end
                        end
                        C_PG_GO, C_CACHE_GO: begin
                            if (st_q.pend == PD_PROG && st_q.loaded && st_q.aidx == st_q.aend) begin
                                st_d.start    = 1'b1;
                                st_d.rdy      = 1'b0;
                                st_d.arr_busy = 1'b1;
                                if (bus_in == C_CACHE_GO) begin
                                    st_d.kind    = OPK_CACHE;
                                    st_d.tmr_run = 1'b1;
                                    st_d.tmr     = TMR_W'(CACHE_BUSY_CYC);
                                end else begin
                                    st_d.kind = OPK_PROG;
                                end
                            end
                            st_d.pend   = PD_NONE;
                            st_d.loaded = 1'b0;
                        end
                        C_ER_SETUP: begin
                            st_d.pend = PD_ERASE;
                            st_d.aidx = 3'd2;
                            st_d.aend = 3'd4;
                        end
                        C_ER_GO: begin
                            if (st_q.pend == PD_ERASE && st_q.aidx == st_q.aend) begin
                                st_d.start    = 1'b1;
                                st_d.kind     = OPK_ERASE;
                                st_d.rdy      = 1'b0;
                                st_d.arr_busy = 1'b1;
                            end
                            st_d.pend = PD_NONE;
                        end
                        C_RO_SETUP: begin
                            st_d.pend = PD_RNDOUT;
                            st_d.aidx = 3'd0;
                            st_d.aend = 3'd2;
                        end
                        C_RO_GO: begin
                            if (st_q.pend == PD_RNDOUT && st_q.aidx == st_q.aend) begin
                                st_d.mode = MD_ARRAY;
                            end
                            st_d.pend = PD_NONE;
                        end
                        C_IDENT: begin
                            st_d.pend = PD_ID;
                            st_d.aidx = 3'd0;
                            st_d.aend = 3'd1;
                        end
                        default: st_d.pend = PD_NONE;
                    endcase
                end
            end else if (ale) begin
                if (st_q.rdy && st_q.pend != PD_NONE && st_q.aidx != st_q.aend) begin
                    st_d.aidx = st_q.aidx + 1'b1;
                    if (st_q.pend == PD_ID) begin
                        if (bus_in == 8'h00) begin
                            st_d.mode   = MD_ID;
                            st_d.id_idx = 3'd0;
                        end
                    end else begin
                        case (st_q.aidx)
                            3'd0: col16[7:0]  = bus_in;
                            3'd1: col16[15:8] = {4'b0000, bus_in[3:0]};
                            3'd2: row16[7:0]  = bus_in;
                            default: row16[15:8] = bus_in;
                        endcase
                        st_d.col = COL_W'(col16);
                        st_d.row = ROW_W'(row16);
                    end
                end
            end else begin
                if (st_q.rdy && st_q.pend == PD_PROG && st_q.aidx == st_q.aend) begin
                    st_d.wr     = 1'b1;
                    st_d.wdat   = bus_in;
                    st_d.loaded = 1'b1;
                end
            end
        end

        if (re_fall && !ce_n) begin
            st_d.dout = rsp_b;
            case (st_q.mode)
                MD_ARRAY: st_d.col = st_q.col + 1'b1;
                MD_ID: if (st_q.id_idx != 3'd5) st_d.id_idx = st_q.id_idx + 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MD_ARRAY;
            st_q.pend     <= PD_READ;
            st_q.aend     <= 3'd4;
            st_q.rdy      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_out  = st_q.dout;
    assign busy_n   = st_q.rdy;
    assign col_addr = st_q.col;
    assign row_addr = st_q.row;
    assign wr_stb   = st_q.wr;
    assign wr_data  = st_q.wdat;
    assign op_start = st_q.start;
    assign op_kind  = st_q.kind;
    assign op_abort = st_q.abort;

    logic unused_ok;
    assign unused_ok = ^{we_fall_unused, re_rise_unused, COL_HI};
endmodule

// File: rtl/nand_cmd_front_chk.sv
module nand_cmd_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_n,
    input logic       op_start,
    input logic [2:0] op_kind,
    input logic       op_abort,
    input logic       wr_stb
);
    AST_START_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(busy_n)); // R6
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !busy_n); // R3
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start); // R3
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (op_kind <= 3'd4)); // R3
    AST_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy_n); // R4
    AST_ABORT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |-> !busy_n); // R9
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |=> !op_abort); // R9
endmodule

bind nand_cmd_front nand_cmd_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .op_start(op_start),
    .op_kind(op_kind), .op_abort(op_abort), .wr_stb(wr_stb)
);

// File: tb/nand_cmd_front_bench.sv
module nand_cmd_front_bench;
    localparam int RSTC = 40;
    localparam int CCHC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, arr_rd_data, wr_data;
    logic busy_n, wr_stb, op_start, op_abort;
    logic op_done = 1'b0, op_fail = 1'b0;
    logic [11:0] col_addr;
    logic [15:0] row_addr;
    logic [2:0] op_kind;

    int n_chk = 0, n_bad = 0;
    int starts = 0, writes = 0;
    logic [2:0]  last_kind;
    logic [15:0] last_row;
    logic [11:0] last_wcol;
    logic [7:0]  last_wdat;
    logic [7:0]  v;

    always #4 clk = ~clk;

    function automatic logic [7:0] pg(input logic [11:0] c);
        return c[7:0] ^ {4'h5, c[11:8]};
    endfunction
    assign arr_rd_data = pg(col_addr);

    nand_cmd_front #(.RST_BUSY_CYC(RSTC), .CACHE_BUSY_CYC(CCHC)) u_nand_cmd_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .bus_in(bus_in), .bus_out(bus_out), .busy_n(busy_n),
        .arr_rd_data(arr_rd_data), .col_addr(col_addr), .row_addr(row_addr),
        .wr_stb(wr_stb), .wr_data(wr_data), .op_start(op_start), .op_kind(op_kind),
        .op_abort(op_abort), .op_done(op_done), .op_fail(op_fail)
    );

    always @(negedge clk) begin
        if (op_start) begin
            starts++;
            last_kind = op_kind;
            last_row  = row_addr;
        end
        if (wr_stb) begin
            writes++;
            last_wcol = col_addr;
            last_wdat = wr_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bw(input logic c, input logic a, input logic [7:0] b, input logic cs = 1'b0);
        @(negedge clk);
        ce_n = cs; cle = c; ale = a; bus_in = b; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b); bw(1'b1, 1'b0, b); endtask
    task automatic adr(input logic [7:0] b); bw(1'b0, 1'b1, b); endtask
    task automatic dat(input logic [7:0] b); bw(1'b0, 1'b0, b); endtask

    task automatic rd(output logic [7:0] r);
        @(negedge clk);
        ce_n = 1'b0; re_n = 1'b0;
        repeat (4) @(negedge clk);
        r = bus_out;
        re_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic done(input logic f);
        @(negedge clk); op_done = 1'b1; op_fail = f;
        @(negedge clk); op_done = 1'b0; op_fail = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic addr4(input logic [11:0] c, input logic [15:0] r);
        adr(c[7:0]); adr({4'h0, c[11:8]}); adr(r[7:0]); adr(r[15:8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int s0;
        logic [11:0] c;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 reset ready", busy_n, 1);
        chk("R3 reset no start", op_start, 0);

        // R3: power-up read without 00h; fifth address byte ignored (R2)
        addr4(12'h123, 16'hBEEF); adr(8'hAA);
        cmd(8'h30);
        chk("R3 start count", starts, 1);
        chk("R3 kind read", last_kind, 0);
        chk("R2 row capture, extra ignored", last_row, 16'hBEEF);
        chk("R3 busy after start", busy_n, 0);
        done(1'b0);
        chk("R3 ready after done", busy_n, 1);
        rd(v); chk("R11 first byte", v, pg(12'h123));
        rd(v); chk("R11 column advanced", v, pg(12'h124));

        // R11 sweep of random output columns; R2 upper nibble mask
        for (int i = 0; i < 6; i++) begin
            c = 12'(i * 12'h2A7 + 12'h011);
            cmd(8'h05); adr(c[7:0]); adr({4'hF, c[11:8]}); cmd(8'hE0);
            for (int k = 0; k < 3; k++) begin
                rd(v); chk("R11 R2 random out", v, pg(c + 12'(k)));
            end
        end

        // R3 read-for-copy
        cmd(8'h00); addr4(12'h000, 16'h0102); cmd(8'h35);
        chk("R3 kind copy", last_kind, 1);
        done(1'b0);

        // R4 lone confirm starts nothing
        s0 = starts;
        cmd(8'h80); addr4(12'h010, 16'h0040); cmd(8'h10);
        chk("R4 lone confirm", starts, s0);
        chk("R4 lone confirm ready", busy_n, 1);

        // R4 program with data and a column move
        cmd(8'h80); addr4(12'h020, 16'h0041);
        dat(8'h5A);
        chk("R4 write col", last_wcol, 12'h020);
        chk("R4 write data", last_wdat, 8'h5A);
        dat(8'h6B);
        chk("R4 write next col", last_wcol, 12'h021);
        cmd(8'h85); adr(8'h40); adr(8'h08);
        dat(8'h7C);
        chk("R4 column move", last_wcol, 12'h840);
        chk("R4 write count", writes, 3);
        cmd(8'h10);
        chk("R4 kind program", last_kind, 2);
        chk("R4 row", last_row, 16'h0041);

        // R6 filter while busy, R7 status while busy
        s0 = starts;
        cmd(8'h00); addr4(12'h0, 16'h0); cmd(8'h30);
        cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
        chk("R6 dropped while busy", starts, s0);
        cmd(8'h70);
        rd(v); chk("R7 status busy", v, 8'h80);
        done(1'b1);
        rd(v); chk("R7 R8 status fail sticky", v, 8'hE1);
        wp_n = 1'b0;
        rd(v); chk("R7 write-protect bit", v, 8'h61);
        wp_n = 1'b1;

        // R5 erase with two row bytes
        cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0);
        chk("R5 kind erase", last_kind, 4);
        chk("R5 erase row", last_row, 16'h1234);
        done(1'b0);

        // R8 back to page data with 00h
        rd(v); chk("R8 still status", v, 8'hE0);
        cmd(8'h00);
        c = col_addr;
        rd(v); chk("R8 page data after 00h", v, pg(c));

        // R1 chip select high ignores, ALE byte is not a command
        bw(1'b1, 1'b0, 8'hFF, 1'b1);
        chk("R1 deselected ignored", busy_n, 1);
        adr(8'h70);
        c = col_addr;
        rd(v); chk("R1 address not command", v, pg(c));

        // R10 ID sequence
        cmd(8'h90); adr(8'h00);
        rd(v); chk("R10 id0", v, 8'hC8);
        rd(v); chk("R10 id1", v, 8'hA1);
        rd(v); chk("R10 id2", v, 8'h80);
        rd(v); chk("R10 id3", v, 8'h15);
        rd(v); chk("R10 id4", v, 8'h40);
        rd(v); chk("R10 past end", v, 8'h00);

        // R12 cache program
        cmd(8'h80); addr4(12'h000, 16'h0042); dat(8'h11); cmd(8'h15);
        chk("R12 kind cache", last_kind, 3);
        chk("R12 busy during transfer", busy_n, 0);
        repeat (CCHC + 8) @(negedge clk);
        chk("R12 ready early", busy_n, 1);
        cmd(8'h70);
        rd(v); chk("R12 array still busy", v, 8'hC0);
        done(1'b0);
        rd(v); chk("R12 array idle", v, 8'hE0);

        // R9 reset aborts a busy operation
        cmd(8'h00); addr4(12'h0, 16'h0); cmd(8'h30);
        cmd(8'hFF);
        chk("R9 busy in reset", busy_n, 0);
        repeat (RSTC + 8) @(negedge clk);
        chk("R9 ready after reset", busy_n, 1);
        cmd(8'h70);
        rd(v); chk("R9 status after reset", v, 8'hE0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule